// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is the serial front end of a register file that can only be written. It runs entirely on the system clock. The SCL and SDA lines pass through a synchronizer, and the block finds bus conditions and clock edges by comparing successive synchronized samples. It answers one 7-bit address. Five upper bits are fixed and the two low bits come from a strap input.

A transfer has three parts. The first is the address byte, with the direction bit at zero. The second is a register-pointer byte. After that come any number of data bytes. The block acknowledges each of these bytes by pulling SDA low for the ninth clock. For every data byte it presents a one-cycle write strobe together with the pointer and the byte. The pointer then advances, so a burst fills consecutive registers.

Read requests, other addresses and traffic that arrives without a START are left unacknowledged. Pad drivers, clock stretching and analog strap sensing are outside the block. The SDA output only asks the pad to pull low.

Top module: `i2cw_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1,1,0,1,1 followed by `strap_i[1]`, `strap_i[0]`, with a direction bit (bit 0, last on the wire) of 0, is acknowledged. This holds for each strap code 00, 01, 10 and 11. Acknowledging means `sda_low_o` is high during the ninth SCL high phase.
- R2: An address byte that differs in any prefix or strap bit gets no acknowledge. Every later byte up to the next START gets no acknowledge and no strobe.
- R3: An address byte with the direction bit at 1 is not acknowledged, and no strobe follows.
- R4: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bytes clocked without a new START get no acknowledge and no strobe.
- R5: The byte after an acknowledged address is acknowledged and loads the register pointer. The first data byte is written to that pointer. Bits are taken on SCL rising edges, MSB first.
- R6: Each data byte is acknowledged. It produces exactly one `wr_strobe_o` pulse, one clock wide, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte.
- R7: After each acknowledged data byte the pointer increases by one, so burst bytes land at consecutive addresses.
- R8: The pointer wraps from 0xFF to 0x00.
- R9: A repeated START at any point returns the block to address reception. A complete write that follows it is honoured.
- R10: After reset, `sda_low_o` and `wr_strobe_o` are low and `wr_addr_o` and `wr_data_o` are zero.
- R11: The write strobe and the acknowledge drive both rise on the third system clock edge after the SCL fall that ends the eighth bit. There are two synchronizer stages and one state register on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 2 | Low two bits of the target address |
| sda_low_o | output | 1 | Request to pull SDA low (acknowledge) |
| wr_strobe_o | output | 1 | One-cycle register write pulse |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 8 | Data byte of the current write |

## Verification
Each bus change reaches the outputs on the third rising clock edge after it is driven. The acknowledge drive, the strobe and the release of SDA all follow this timing. The bench holds every SCL phase for eight system clocks and reads the acknowledge in the middle of the ninth SCL high phase, well after the drive has settled. Strobes are logged on falling clock edges and compared with the expected address and data after each transfer. One data byte is also checked on the exact cycle: the strobe must be low on the second falling clock edge after the SCL fall and high on the third.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_REG      = 3'd3,
        ST_REG_ACK  = 3'd4,
        ST_DATA     = 3'd5,
        ST_DATA_ACK = 3'd6,
        ST_SKIP     = 3'd7
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bits;
        logic [BYTE_W-1:0]   shift;
        logic [BYTE_W-1:0]   ptr;
        logic                drive;
        logic                stb;
        logic [BYTE_W-1:0]   wa;
        logic [BYTE_W-1:0]   wd;
    } eng_s;

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] prev_o
);

    localparam int TOP = STAGES;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TOP:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[TOP-1:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign level_o[g] = chain_q[TOP-1];
        assign prev_o[g]  = chain_q[TOP];
    end

endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
    input  logic scl_i,
    input  logic scl_prev_i,
    input  logic sda_i,
    input  logic sda_prev_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_steady_high;

    always_comb begin
        scl_steady_high = scl_i & scl_prev_i;
        scl_rise_o      = scl_i & ~scl_prev_i;
        scl_fall_o      = ~scl_i & scl_prev_i;
        start_o         = scl_steady_high & sda_prev_i & ~sda_i;
        stop_o          = scl_steady_high & ~sda_prev_i & sda_i;
    end

endmodule

// File: rtl/i2cw_xfer_engine.sv
module i2cw_xfer_engine
    import i2cw_pkg::*;
#(
    parameter int                 STRAP_W     = 2,
    parameter logic [6-STRAP_W:0] ADDR_PREFIX = 5'b11011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_low_o,
    output logic               wr_strobe_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    eng_s q, d;
    logic receiving;
    logic addr_hit;

    always_comb begin
        receiving = (q.phase == ST_ADDR) || (q.phase == ST_REG) || (q.phase == ST_DATA);
        addr_hit  = (q.shift[BYTE_W-1:1] == {ADDR_PREFIX, strap_i}) && !q.shift[0];
    end

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (stop_i) begin
            d.phase = ST_IDLE;
            d.drive = 1'b0;
            d.bits  = '0;
        end else if (start_i) begin
            d.phase = ST_ADDR;
            d.drive = 1'b0;
            d.bits  = '0;
        end else if (scl_rise_i) begin
            if (receiving && q.bits < FULL) begin
                d.shift = {q.shift[BYTE_W-2:0], sda_i};
                d.bits  = q.bits + 1'b1;
            end
        end else if (scl_fall_i) begin
            case (q.phase)
                ST_ADDR: begin
                    if (q.bits == FULL) begin
                        if (addr_hit) begin
                            d.phase = ST_ADDR_ACK;
                            d.drive = 1'b1;
                        end else begin
                            d.phase = ST_SKIP;
                        end
                    end
                end
                ST_REG: begin
                    if (q.bits == FULL) begin
                        d.phase = ST_REG_ACK;
                        d.drive = 1'b1;
                        d.ptr   = q.shift;
                    end
                end
                ST_DATA: begin
                    if (q.bits == FULL) begin
                        d.phase = ST_DATA_ACK;
                        d.drive = 1'b1;
                        d.stb   = 1'b1;
                        d.wa    = q.ptr;
                        d.wd    = q.shift;
                    end
                end
                ST_ADDR_ACK: begin
                    d.phase = ST_REG;
                    d.drive = 1'b0;
                    d.bits  = '0;
                end
                ST_REG_ACK: begin
                    d.phase = ST_DATA;
                    d.drive = 1'b0;
                    d.bits  = '0;
                end
                ST_DATA_ACK: begin
                    d.phase = ST_DATA;
                    d.drive = 1'b0;
                    d.bits  = '0;
                    d.ptr   = q.ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_low_o   = q.drive;
    assign wr_strobe_o = q.stb;
    assign wr_addr_o   = q.wa;
    assign wr_data_o   = q.wd;

    // R6: a write strobe never lasts more than one clock
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb);

    // R6: a strobe always comes with the acknowledge of its byte
    p_strobe_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> q.drive);

    // R11: the acknowledge drive starts only after a detected SCL fall
    p_ack_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.drive) |-> $past(scl_fall_i));

    // R4: SDA is released only on an SCL fall or a bus condition
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.drive) |-> $past(scl_fall_i || start_i || stop_i));

    // R4: a STOP leaves the engine idle with the line released
    p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.phase == ST_IDLE && !q.drive));

    // R9: a START always restarts address reception
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (q.phase == ST_ADDR && q.bits == '0));

    // R7: leaving a data acknowledge advances the pointer by one
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.phase) == ST_DATA_ACK && q.phase == ST_DATA)
            |-> q.ptr == BYTE_W'($past(q.ptr) + 1'b1));

    // R2: an unaddressed transfer stays silent
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_SKIP) |-> (!q.drive && !q.stb));

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target
    import i2cw_pkg::*;
#(
    parameter int                 STRAP_W     = 2,
    parameter logic [6-STRAP_W:0] ADDR_PREFIX = 5'b11011,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_low_o,
    output logic               wr_strobe_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);

    logic [1:0] line_lvl, line_prev;
    logic       scl_rise, scl_fall, bus_start, bus_stop;

    i2cw_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sda_i, scl_i}),
        .level_o (line_lvl),
        .prev_o  (line_prev)
    );

    i2cw_bus_events u_events (
        .scl_i      (line_lvl[0]),
        .scl_prev_i (line_prev[0]),
        .sda_i      (line_lvl[1]),
        .sda_prev_i (line_prev[1]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2cw_xfer_engine #(.STRAP_W(STRAP_W), .ADDR_PREFIX(ADDR_PREFIX)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_i       (line_lvl[1]),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (bus_start),
        .stop_i      (bus_stop),
        .strap_i     (strap_i),
        .sda_low_o   (sda_low_o),
        .wr_strobe_o (wr_strobe_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

endmodule

// File: tb/i2cw_target_tb.sv
module i2cw_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_low, stb;
    logic [7:0] wa, wd;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_low;

    int n_chk = 0;
    int n_fail = 0;
    int n_log = 0;
    bit done = 1'b0;
    logic [7:0] log_a [64];
    logic [7:0] log_d [64];

    i2cw_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .strap_i     (strap),
        .sda_low_o   (sda_low),
        .wr_strobe_o (stb),
        .wr_addr_o   (wa),
        .wr_data_o   (wd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && stb && n_log < 64) begin
            log_a[n_log] = wa;
            log_d[n_log] = wd;
            n_log++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b0; hold(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b1; hold(HALF);
    endtask

    // Sends one byte MSB first and returns whether the ninth clock saw SDA low.
    task automatic send_byte(input logic [7:0] b, input bit lat, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(HALF);
            scl_m = 1'b1; hold(HALF);
            scl_m = 1'b0;
            if (i == 0 && lat) begin
                hold(2);
                chk(stb == 1'b0, "R11 strobe low at 2nd edge", stb, 0);
                hold(1);
                chk(stb == 1'b1, "R11 strobe high at 3rd edge", stb, 1);
                chk(sda_low == 1'b1, "R11 ack drive at 3rd edge", sda_low, 1);
                hold(HALF - 3);
            end else begin
                hold(HALF);
            end
        end
        sda_m = 1'b1; hold(HALF);
        scl_m = 1'b1; hold(HALF/2);
        ack = ~sda_bus;
        hold(HALF/2);
        scl_m = 1'b0; hold(HALF);
    endtask

    task automatic expect_write(input int idx, input logic [7:0] a, input logic [7:0] dat,
                                input string req);
        chk(log_a[idx] == a, req, log_a[idx], a);
        chk(log_d[idx] == dat, req, log_d[idx], dat);
    endtask

    task automatic t_reset();
        chk(sda_low == 1'b0, "R10 sda idle", sda_low, 0);
        chk(stb == 1'b0, "R10 strobe idle", stb, 0);
        chk(wa == 8'h00 && wd == 8'h00, "R10 outputs zero", {wa, wd}, 0);
    endtask

    task automatic t_each_strap();
        bit ack;
        logic [1:0] codes [4] = '{2'b00, 2'b11, 2'b01, 2'b10};
        for (int k = 0; k < 4; k++) begin
            int base = n_log;
            strap = codes[k];
            bus_start();
            send_byte({5'b11011, codes[k], 1'b0}, 1'b0, ack);
            chk(ack, "R1 address ack", ack, 1);
            send_byte(8'h04 + 8'(k), 1'b0, ack);
            chk(ack, "R5 register ack", ack, 1);
            send_byte(8'hA5 ^ 8'(k), k == 0, ack);
            chk(ack, "R6 data ack", ack, 1);
            bus_stop();
            chk(n_log == base + 1, "R6 one strobe", n_log - base, 1);
            expect_write(base, 8'h04 + 8'(k), 8'hA5 ^ 8'(k), "R5 R6 write content");
        end
    endtask

    task automatic t_burst();
        bit ack;
        int base = n_log;
        strap = 2'b10;
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        send_byte(8'h10, 1'b0, ack);
        send_byte(8'h11, 1'b0, ack);
        send_byte(8'h22, 1'b0, ack);
        send_byte(8'h33, 1'b0, ack);
        chk(ack, "R7 last burst byte ack", ack, 1);
        bus_stop();
        chk(n_log == base + 3, "R7 burst count", n_log - base, 3);
        expect_write(base,     8'h10, 8'h11, "R7 burst 0");
        expect_write(base + 1, 8'h11, 8'h22, "R7 burst 1");
        expect_write(base + 2, 8'h12, 8'h33, "R7 burst 2");
    endtask

    task automatic t_wrap();
        bit ack;
        int base = n_log;
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        send_byte(8'hFE, 1'b0, ack);
        send_byte(8'h01, 1'b0, ack);
        send_byte(8'h02, 1'b0, ack);
        send_byte(8'h03, 1'b0, ack);
        bus_stop();
        chk(n_log == base + 3, "R8 wrap count", n_log - base, 3);
        expect_write(base + 1, 8'hFF, 8'h02, "R8 at FF");
        expect_write(base + 2, 8'h00, 8'h03, "R8 wrapped to 00");
    endtask

    task automatic t_mismatch();
        bit ack;
        int base = n_log;
        strap = 2'b10;
        bus_start();
        send_byte(8'b1101_1010, 1'b0, ack);
        chk(!ack, "R2 wrong strap nack", ack, 0);
        send_byte(8'h05, 1'b0, ack);
        chk(!ack, "R2 later byte nack", ack, 0);
        send_byte(8'h77, 1'b0, ack);
        chk(!ack, "R2 data byte nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'b1100_1100, 1'b0, ack);
        chk(!ack, "R2 wrong prefix nack", ack, 0);
        bus_stop();
        chk(n_log == base, "R2 no strobe", n_log - base, 0);
    endtask

    task automatic t_read();
        bit ack;
        int base = n_log;
        bus_start();
        send_byte(8'b1101_1101, 1'b0, ack);
        chk(!ack, "R3 read nack", ack, 0);
        send_byte(8'h00, 1'b0, ack);
        bus_stop();
        chk(n_log == base, "R3 no strobe", n_log - base, 0);
    endtask

    task automatic t_after_stop();
        bit ack;
        int base = n_log;
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        send_byte(8'h40, 1'b0, ack);
        bus_stop();
        scl_m = 1'b0; hold(HALF);
        send_byte(8'h99, 1'b0, ack);
        chk(!ack, "R4 byte after stop nack", ack, 0);
        send_byte(8'b1101_1100, 1'b0, ack);
        chk(!ack, "R4 address without start nack", ack, 0);
        scl_m = 1'b1; hold(HALF);
        chk(n_log == base, "R4 no strobe after stop", n_log - base, 0);
        chk(sda_low == 1'b0, "R4 line released", sda_low, 0);
    endtask

    task automatic t_restart();
        bit ack;
        int base = n_log;
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        send_byte(8'h20, 1'b0, ack);
        send_byte(8'h5A, 1'b0, ack);
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        chk(ack, "R9 address after restart ack", ack, 1);
        send_byte(8'h30, 1'b0, ack);
        send_byte(8'h6B, 1'b0, ack);
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        send_byte(8'h44, 1'b0, ack);
        bus_start();
        send_byte(8'b1101_1100, 1'b0, ack);
        send_byte(8'h50, 1'b0, ack);
        send_byte(8'hC3, 1'b0, ack);
        bus_stop();
        chk(n_log == base + 3, "R9 restart count", n_log - base, 3);
        expect_write(base,     8'h20, 8'h5A, "R9 before restart");
        expect_write(base + 1, 8'h30, 8'h6B, "R9 after restart");
        expect_write(base + 2, 8'h50, 8'hC3, "R9 restart mid pointer");
    endtask

    initial begin
        hold(4);
        rst_n = 1'b1;
        hold(4);
        t_reset();
        t_each_strap();
        t_burst();
        t_wrap();
        t_mismatch();
        t_read();
        t_after_stop();
        t_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule